// File: doc/BRIEF.md
# Protection Interrupt Router

This block sits between a set of access-gate controllers and a word-addressed register bus. Each gate controller raises a level interrupt-status line; the router samples all of them every cycle into one packed status word. It also keeps a packed enable word whose bits drive one enable line per controller, and on a write of the clear word it pulses one clear line per controller. A bridge-interrupt enable word is kept for software, and the matching bridge status always reads as zero.

The controllers fall into three groups: two internal gates, four expansion gates on the peripheral bus and four expansion gates on the system bus. Each group occupies its own bit range in the packed words, so the legal bits form the sparse mask 0x00F000F3. Software sees the register file through a simple request interface; read data comes back one cycle after the request.

Top module: `secirq_router`

## Requirements
- R1: Controller index 0..1 (internal gates) maps to status bits 0..1, index 2..5 (peripheral-bus expansion gates 0..3) maps to bits 4..7, and index 6..9 (system-bus expansion gates 0..3) maps to bits 20..23. A word read of offset 0x20 returns the inputs as sampled one cycle before the read request, in this layout, with all other bits zero.
- R2: A word write to the enable register at offset 0x28 stores only the bits in mask 0x00F000F3; a read of 0x28 returns the stored value.
- R3: Each controller's enable output equals its bit of the enable register (bit position as in R1), changing in the cycle after the write.
- R4: A word write to the clear register at offset 0x24 drives, in the following cycle only, the clear output of every controller whose bit (position as in R1) is 1 in the written value; bits outside 0x00F000F3 are dropped, and a read of 0x24 returns zero.
- R5: The bridge enable register at offset 0x48 keeps only bits [31:16] of a word write; the bridge status at 0x40 always reads zero; a write to the bridge clear at 0x44 changes nothing.
- R6: Writes to the status offsets 0x20 and 0x40 have no effect, and a read of any offset not listed in R1, R2, R4 or R5 returns zero.
- R7: Writes whose size code (bus_size: 0 byte, 1 halfword, 2 word, 3 reserved) is not 2 are ignored: no register changes and no clear pulse.
- R8: A byte read (size 0) returns byte bus_addr[1:0] of the addressed word in bits [7:0]; a halfword read (size 1) returns the 16 bits starting at that byte in bits [15:0]; the upper bits are zero. Size codes 2 and 3 read the whole word.
- R9: Synchronous active-low reset clears the status, enable, clear, bridge enable and read-data registers; all enable and clear outputs are low afterwards.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address of the access |
| bus_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 reserved |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| gate_irq_status | input | 10 | Level interrupt status from each gate controller |
| gate_irq_enable | output | 10 | Interrupt enable to each gate controller |
| gate_irq_clear | output | 10 | One-cycle interrupt clear to each gate controller |

## Verification
The status path is driven with a walking one across all ten controllers, which separates every controller's bit position and catches a lane swapped within or between groups, then with all-ones and an alternating pattern that expose stuck or merged bits. The enable and clear registers are written with all-ones, proving the sparse mask, and with a scattered pattern touching each group, which shows that the decoded per-controller outputs come from the right bits. Narrow writes and byte or halfword reads at each lane offset distinguish a correct size check and lane shift from ones that ignore the size code or the low address bits.

// File: rtl/secirq_pkg.sv
// Package: shared encodings, register offsets and the controller-to-bit
// placement used by every module of the protection interrupt router.
// Assumes byte addressing with 32-bit aligned registers.
package secirq_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_STATUS,
        RG_CLEAR,
        RG_ENABLE,
        RG_BSTAT,
        RG_BCLEAR,
        RG_BENABLE
    } reg_sel_e;

    localparam logic [11:0] OFF_STATUS  = 12'h020;
    localparam logic [11:0] OFF_CLEAR   = 12'h024;
    localparam logic [11:0] OFF_ENABLE  = 12'h028;
    localparam logic [11:0] OFF_BSTAT   = 12'h040;
    localparam logic [11:0] OFF_BCLEAR  = 12'h044;
    localparam logic [11:0] OFF_BENABLE = 12'h048;

    // Bit position of controller idx inside the packed words.
    function automatic int lane_bit(input int idx, input int n_int, input int n_apbx,
                                    input int b_int, input int b_apbx, input int b_ahbx);
        if (idx < n_int)
            return b_int + idx;
        else if (idx < n_int + n_apbx)
            return b_apbx + idx - n_int;
        else
            return b_ahbx + idx - n_int - n_apbx;
    endfunction

    // Controller owning packed bit b, or -1 when the bit is unused.
    function automatic int lane_owner(input int b, input int n_int, input int n_apbx,
                                      input int n_ahbx, input int b_int, input int b_apbx,
                                      input int b_ahbx);
        for (int i = 0; i < n_int + n_apbx + n_ahbx; i++) begin
            if (lane_bit(i, n_int, n_apbx, b_int, b_apbx, b_ahbx) == b)
                return i;
        end
        return -1;
    endfunction

    // Mask of all packed bits that carry a controller.
    function automatic logic [31:0] lane_mask(input int n_int, input int n_apbx,
                                              input int n_ahbx, input int b_int,
                                              input int b_apbx, input int b_ahbx);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n_int + n_apbx + n_ahbx; i++)
            m[lane_bit(i, n_int, n_apbx, b_int, b_apbx, b_ahbx)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/secirq_decode.sv
// Module: turns the word part of a bus address into a register select.
// Assumes the byte-lane bits have already been stripped by the caller.
module secirq_decode
    import secirq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LANE_AW = 2
) (
    input  logic [ADDR_W-LANE_AW-1:0] word_addr,
    output reg_sel_e                  sel_o
);

    localparam int WA_W = ADDR_W - LANE_AW;

    // Compare the word address against every implemented offset.
    always_comb begin
        if (word_addr == WA_W'(OFF_STATUS >> LANE_AW))
            sel_o = RG_STATUS;
        else if (word_addr == WA_W'(OFF_CLEAR >> LANE_AW))
            sel_o = RG_CLEAR;
        else if (word_addr == WA_W'(OFF_ENABLE >> LANE_AW))
            sel_o = RG_ENABLE;
        else if (word_addr == WA_W'(OFF_BSTAT >> LANE_AW))
            sel_o = RG_BSTAT;
        else if (word_addr == WA_W'(OFF_BCLEAR >> LANE_AW))
            sel_o = RG_BCLEAR;
        else if (word_addr == WA_W'(OFF_BENABLE >> LANE_AW))
            sel_o = RG_BENABLE;
        else
            sel_o = RG_NONE;
    end

endmodule

// File: rtl/secirq_gather.sv
// Module: places a per-controller vector into the sparse packed layout.
// Assumes every group base lies inside DATA_W; unused bits are driven low.
module secirq_gather
    import secirq_pkg::*;
#(
    parameter int N_INT  = 2,
    parameter int N_APBX = 4,
    parameter int N_AHBX = 4,
    parameter int B_INT  = 0,
    parameter int B_APBX = 4,
    parameter int B_AHBX = 20,
    parameter int DATA_W = 32
) (
    input  logic [N_INT+N_APBX+N_AHBX-1:0] ctl_i,
    output logic [DATA_W-1:0]              packed_o
);

    // One generate step per packed bit: route its owner or tie it low.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        localparam int OWNER = lane_owner(b, N_INT, N_APBX, N_AHBX, B_INT, B_APBX, B_AHBX);
        if (OWNER >= 0) begin : g_used
            assign packed_o[b] = ctl_i[OWNER];
        end else begin : g_free
            assign packed_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/secirq_router.sv
// Module: protection interrupt status and control router (top).
// Samples each gate controller's status line, holds the enable and
// bridge enable registers, pulses per-controller clears and serves a
// simple request bus with one-cycle read latency.
// Assumes byte addresses, word-aligned registers and a single clock.
module secirq_router
    import secirq_pkg::*;
#(
    parameter int N_INT       = 2,
    parameter int N_APBX      = 4,
    parameter int N_AHBX      = 4,
    parameter int B_INT       = 0,
    parameter int B_APBX      = 4,
    parameter int B_AHBX      = 20,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter logic [31:0] BRG_EN_MASK = 32'hFFFF_0000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [1:0]                      bus_size,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    input  logic [N_INT+N_APBX+N_AHBX-1:0]  gate_irq_status,
    output logic [N_INT+N_APBX+N_AHBX-1:0]  gate_irq_enable,
    output logic [N_INT+N_APBX+N_AHBX-1:0]  gate_irq_clear
);

    localparam int N_CTRL  = N_INT + N_APBX + N_AHBX;
    localparam int LANE_AW = $clog2(DATA_W / 8);
    localparam logic [DATA_W-1:0] LANE_MASK =
        DATA_W'(lane_mask(N_INT, N_APBX, N_AHBX, B_INT, B_APBX, B_AHBX));
    localparam logic [DATA_W-1:0] BRG_MASK  = DATA_W'(BRG_EN_MASK);
    localparam logic [DATA_W-1:0] BYTE_M    = DATA_W'(16'h00FF);
    localparam logic [DATA_W-1:0] HALF_M    = DATA_W'(16'hFFFF);

    reg_sel_e              sel_w;
    acc_size_e             size_w;
    logic                  word_wr;
    logic                  rd_req;
    logic [N_CTRL-1:0]     wr_lanes;
    logic [N_CTRL-1:0]     status_q;
    logic [N_CTRL-1:0]     enable_q;
    logic [N_CTRL-1:0]     clear_q;
    logic [DATA_W-1:0]     bren_q;
    logic [DATA_W-1:0]     status_pk;
    logic [DATA_W-1:0]     enable_pk;
    logic [DATA_W-1:0]     word_val;
    logic [DATA_W-1:0]     shifted;
    logic [DATA_W-1:0]     rd_val;
    logic [DATA_W-1:0]     rdata_q;
    logic                  unused_wdata;

    // Address decode of the word part of the request.
    secirq_decode #(
        .ADDR_W (ADDR_W),
        .LANE_AW(LANE_AW)
    ) dec_i (
        .word_addr(bus_addr[ADDR_W-1:LANE_AW]),
        .sel_o    (sel_w)
    );

    // Packed views of the sampled status and stored enable vectors.
    secirq_gather #(
        .N_INT(N_INT), .N_APBX(N_APBX), .N_AHBX(N_AHBX),
        .B_INT(B_INT), .B_APBX(B_APBX), .B_AHBX(B_AHBX), .DATA_W(DATA_W)
    ) gat_status_i (
        .ctl_i   (status_q),
        .packed_o(status_pk)
    );

    secirq_gather #(
        .N_INT(N_INT), .N_APBX(N_APBX), .N_AHBX(N_AHBX),
        .B_INT(B_INT), .B_APBX(B_APBX), .B_AHBX(B_AHBX), .DATA_W(DATA_W)
    ) gat_enable_i (
        .ctl_i   (enable_q),
        .packed_o(enable_pk)
    );

    // Qualify the request: only full-word writes change state.
    assign size_w  = acc_size_e'(bus_size);
    assign word_wr = bus_sel & bus_wr & (size_w == SZ_WORD);
    assign rd_req  = bus_sel & ~bus_wr;

    // Pick each controller's bit out of the write data.
    for (genvar g = 0; g < N_CTRL; g++) begin : g_lane
        localparam int LB = lane_bit(g, N_INT, N_APBX, B_INT, B_APBX, B_AHBX);
        assign wr_lanes[g] = bus_wdata[LB];
    end

    // Write-data bits that no register keeps.
    assign unused_wdata = ^(bus_wdata & ~(LANE_MASK | BRG_MASK));

    // Sample the level status inputs every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= gate_irq_status;
    end

    // Enable register, one bit per controller.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (word_wr && sel_w == RG_ENABLE)
            enable_q <= wr_lanes;
    end

    // Clear pulse, high for the single cycle after a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clear_q <= '0;
        else if (word_wr && sel_w == RG_CLEAR)
            clear_q <= wr_lanes;
        else
            clear_q <= '0;
    end

    // Bridge interrupt enable, upper half only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bren_q <= '0;
        else if (word_wr && sel_w == RG_BENABLE)
            bren_q <= bus_wdata & BRG_MASK;
    end

    // Read multiplexer over the implemented offsets.
    always_comb begin
        case (sel_w)
            RG_STATUS:  word_val = status_pk;
            RG_ENABLE:  word_val = enable_pk;
            RG_BENABLE: word_val = bren_q;
            default:    word_val = '0;
        endcase
    end

    // Narrow reads: shift the addressed byte lane down and trim.
    always_comb begin
        shifted = word_val >> {bus_addr[LANE_AW-1:0], 3'b000};
        case (size_w)
            SZ_BYTE: rd_val = shifted & BYTE_M;
            SZ_HALF: rd_val = shifted & HALF_M;
            default: rd_val = word_val;
        endcase
    end

    // Register the read data; it holds until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_req)
            rdata_q <= rd_val;
    end

    assign bus_rdata       = rdata_q;
    assign gate_irq_enable = enable_q;
    assign gate_irq_clear  = clear_q;

endmodule

// File: rtl/secirq_router_chk.sv
// Module: protocol checker for the protection interrupt router, bound
// to every instance of the top. Observes ports only.
module secirq_router_chk
    import secirq_pkg::*;
#(
    parameter int N_INT  = 2,
    parameter int N_APBX = 4,
    parameter int N_AHBX = 4,
    parameter int B_INT  = 0,
    parameter int B_APBX = 4,
    parameter int B_AHBX = 20,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_sel,
    input logic                            bus_wr,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [1:0]                      bus_size,
    input logic [DATA_W-1:0]               bus_rdata,
    input logic [N_INT+N_APBX+N_AHBX-1:0]  gate_irq_enable,
    input logic [N_INT+N_APBX+N_AHBX-1:0]  gate_irq_clear
);

    localparam logic [DATA_W-1:0] LANE_MASK =
        DATA_W'(lane_mask(N_INT, N_APBX, N_AHBX, B_INT, B_APBX, B_AHBX));

    logic word_acc;
    logic hit_status, hit_clear, hit_enable, hit_bstat;

    // Decode the request independently of the design.
    always_comb begin
        word_acc   = (bus_size == 2'd2);
        hit_status = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_STATUS >> 2));
        hit_clear  = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_CLEAR  >> 2));
        hit_enable = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_ENABLE >> 2));
        hit_bstat  = (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(OFF_BSTAT  >> 2));
    end

    assert_clear_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_irq_clear != '0) |-> $past(bus_sel && bus_wr && word_acc && hit_clear));

    assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && word_acc && hit_enable) |=> $stable(gate_irq_enable));

    assert_narrow_noclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !word_acc) |=> (gate_irq_clear == '0));

    assert_bridge_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && hit_bstat) |=> (bus_rdata == '0));

    assert_clear_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && hit_clear) |=> (bus_rdata == '0));

    assert_enable_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && word_acc && hit_enable) |=> ((bus_rdata & ~LANE_MASK) == '0));

    assert_status_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && word_acc && hit_status) |=> ((bus_rdata & ~LANE_MASK) == '0));

endmodule

bind secirq_router secirq_router_chk #(
    .N_INT(N_INT), .N_APBX(N_APBX), .N_AHBX(N_AHBX),
    .B_INT(B_INT), .B_APBX(B_APBX), .B_AHBX(B_AHBX),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_size       (bus_size),
    .bus_rdata      (bus_rdata),
    .gate_irq_enable(gate_irq_enable),
    .gate_irq_clear (gate_irq_clear)
);

// File: tb/secirq_router_tb_top.sv
// Directed bench for the protection interrupt router: one task per
// scenario, each checking its own results at the falling clock edge.
`timescale 1ns/1ps
module secirq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [9:0]  gate_irq_status;
    logic [9:0]  gate_irq_enable;
    logic [9:0]  gate_irq_clear;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    secirq_router dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_size       (bus_size),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .gate_irq_status(gate_irq_status),
        .gate_irq_enable(gate_irq_enable),
        .gate_irq_clear (gate_irq_clear)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Bit placement from R1.
    function automatic int pos(input int i);
        if (i < 2) return i;
        if (i < 6) return i + 2;
        return i + 14;
    endfunction

    function automatic logic [31:0] pack(input logic [9:0] v);
        logic [31:0] w = '0;
        for (int i = 0; i < 10; i++) w[pos(i)] = v[i];
        return w;
    endfunction

    function automatic logic [9:0] unpack(input logic [31:0] w);
        logic [9:0] v;
        for (int i = 0; i < 10; i++) v[i] = w[pos(i)];
        return v;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [1:0] s);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_size = s;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_size = s;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic set_status(input logic [9:0] v);
        @(negedge clk);
        gate_irq_status = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R9", "enable outputs after reset", 32'(gate_irq_enable), 32'h0);
        check("R9", "clear outputs after reset", 32'(gate_irq_clear), 32'h0);
        bus_read(12'h028, 2'd2, d);
        check("R9", "enable register after reset", d, 32'h0);
        bus_read(12'h048, 2'd2, d);
        check("R9", "bridge enable after reset", d, 32'h0);
        bus_read(12'h020, 2'd2, d);
        check("R9", "status after reset", d, 32'h0);
    endtask

    task automatic t_status_map();
        logic [31:0] d;
        for (int i = 0; i < 10; i++) begin
            set_status(10'(1 << i));
            bus_read(12'h020, 2'd2, d);
            check("R1", $sformatf("walking one ctrl %0d", i), d, 32'(1) << pos(i));
        end
        set_status(10'h3FF);
        bus_read(12'h020, 2'd2, d);
        check("R1", "all controllers", d, 32'h00F0_00F3);
        set_status(10'h2AA);
        bus_read(12'h020, 2'd2, d);
        check("R1", "alternating pattern", d, pack(10'h2AA));
        set_status(10'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        bus_write(12'h028, 32'hFFFF_FFFF, 2'd2);
        check("R3", "enable outputs all set", 32'(gate_irq_enable), 32'h3FF);
        bus_read(12'h028, 2'd2, d);
        check("R2", "enable mask", d, 32'h00F0_00F3);
        bus_write(12'h028, 32'h0050_0021, 2'd2);
        check("R3", "enable outputs scattered", 32'(gate_irq_enable),
              32'(unpack(32'h0050_0021)));
        bus_read(12'h028, 2'd2, d);
        check("R2", "enable scattered readback", d, 32'h0050_0021);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        bus_write(12'h024, 32'h00A0_0012, 2'd2);
        check("R4", "clear pulse lanes", 32'(gate_irq_clear), 32'(unpack(32'h00A0_0012)));
        @(negedge clk);
        check("R4", "clear pulse ends", 32'(gate_irq_clear), 32'h0);
        bus_write(12'h024, 32'hFF0F_0F0C, 2'd2);
        check("R4", "clear outside mask", 32'(gate_irq_clear), 32'h0);
        bus_write(12'h024, 32'hFFFF_FFFF, 2'd2);
        check("R4", "clear all", 32'(gate_irq_clear), 32'h3FF);
        bus_read(12'h024, 2'd2, d);
        check("R4", "clear reads zero", d, 32'h0);
    endtask

    task automatic t_bridge();
        logic [31:0] d;
        bus_write(12'h048, 32'hFFFF_FFFF, 2'd2);
        bus_read(12'h048, 2'd2, d);
        check("R5", "bridge enable mask", d, 32'hFFFF_0000);
        bus_write(12'h044, 32'hFFFF_FFFF, 2'd2);
        bus_read(12'h048, 2'd2, d);
        check("R5", "bridge clear has no effect", d, 32'hFFFF_0000);
        set_status(10'h3FF);
        bus_read(12'h040, 2'd2, d);
        check("R5", "bridge status zero", d, 32'h0);
        set_status(10'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        set_status(10'h155);
        bus_write(12'h020, 32'h0, 2'd2);
        bus_write(12'h040, 32'hFFFF_FFFF, 2'd2);
        bus_read(12'h020, 2'd2, d);
        check("R6", "status ignores writes", d, pack(10'h155));
        bus_read(12'h040, 2'd2, d);
        check("R6", "bridge status ignores writes", d, 32'h0);
        bus_read(12'h030, 2'd2, d);
        check("R6", "undecoded offset", d, 32'h0);
        set_status(10'h0);
    endtask

    task automatic t_narrow_write();
        logic [31:0] d;
        bus_write(12'h028, 32'h00F0_00F3, 2'd2);
        bus_write(12'h028, 32'h0, 2'd0);
        check("R7", "byte write keeps enable outputs", 32'(gate_irq_enable), 32'h3FF);
        bus_write(12'h028, 32'h0, 2'd1);
        bus_write(12'h028, 32'h0, 2'd3);
        bus_read(12'h028, 2'd2, d);
        check("R7", "half and reserved writes keep enable", d, 32'h00F0_00F3);
        bus_write(12'h024, 32'hFFFF_FFFF, 2'd1);
        check("R7", "half write to clear no pulse", 32'(gate_irq_clear), 32'h0);
    endtask

    task automatic t_narrow_read();
        logic [31:0] d;
        bus_write(12'h028, 32'h00F0_00F3, 2'd2);
        bus_read(12'h028, 2'd0, d);
        check("R8", "byte lane 0", d, 32'h0000_00F3);
        bus_read(12'h02A, 2'd0, d);
        check("R8", "byte lane 2", d, 32'h0000_00F0);
        bus_read(12'h029, 2'd1, d);
        check("R8", "half from lane 1", d, 32'h0000_F000);
        bus_read(12'h02A, 2'd1, d);
        check("R8", "half from lane 2", d, 32'h0000_00F0);
        bus_read(12'h02A, 2'd3, d);
        check("R8", "reserved size reads word", d, 32'h00F0_00F3);
    endtask

    task automatic t_reset_mid();
        logic [31:0] d;
        bus_write(12'h028, 32'h00F0_00F3, 2'd2);
        bus_write(12'h048, 32'hFFFF_0000, 2'd2);
        do_reset();
        check("R9", "enable outputs cleared by reset", 32'(gate_irq_enable), 32'h0);
        bus_read(12'h048, 2'd2, d);
        check("R9", "bridge enable cleared by reset", d, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_size = 2'd2; bus_wdata = '0; gate_irq_status = '0;
        do_reset();
        t_reset();
        t_status_map();
        t_enable();
        t_clear();
        t_bridge();
        t_readonly();
        t_narrow_write();
        t_narrow_read();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule